// File: doc/BRIEF.md
# Stop-Mode Clock Gate with Warm-Up Delay

This block controls the deepest power state of a small microcontroller core. Software enters that state by writing a stop request into the power control register on the special-function-register write port. From the next oscillator cycle the block drops the core clock enable, so every part of the core clocked through that enable stops.

The block itself stays on the free-running oscillator. It watches four external interrupt lines for rising edges, and only such an edge or a reset can end the stopped state. An interrupt wake does not restore clocking at once. The block first runs a warm-up counter for 65,536 oscillator cycles so that the crystal can settle. It then clears the stop request, raises the clock enable again and pulses a wake request so the interrupt logic can service the event. Reset cancels everything at any point and returns the block to normal running.

Top module: `stop_ctl`

## Requirements
- R1: A write to register address 0x87 whose bit 1 is 1 drops core_clk_en from the next cycle. A write to any other address, or to 0x87 with bit 1 at 0, leaves core_clk_en high. No bit of the written byte other than bit 1 has any effect.
- R2: core_clk_en stays low in every cycle from the stop request until the warm-up ends.
- R3: While stopped, only a rising edge on one of ext_irq[3:0] ends the stop. A line already held high, a falling edge, or a register write while stopped (including a write that clears bit 1) keeps the block stopped.
- R4: Each ext_irq line passes through two synchronizing flops clocked by osc_clk and then an edge-detect flop. A level change therefore wins its wake on the third rising edge of osc_clk after the change.
- R5: A warm-up lasts exactly 65,536 osc_clk cycles. Measured from the cycle in which a wake edge is driven, core_clk_en returns high on the 65,539th rising edge.
- R6: The stop request clears itself when the warm-up ends, so core_clk_en stays high afterwards without any further write.
- R7: After an interrupt wake, wake_req is high for exactly one cycle. That cycle is the first one in which core_clk_en is high again.
- R8: While rst_n is low, core_clk_en is high and wake_req is low. A reset during a stop or a warm-up aborts it without a wake_req pulse. It also clears the warm-up count, so the next warm-up again lasts the full 65,536 cycles.
- R9: Edges on ext_irq while the core is running change neither core_clk_en nor wake_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| ext_irq | input | 4 | External interrupt lines, rising-edge wake sources |
| core_clk_en | output | 1 | Enable for the gated core clock |
| wake_req | output | 1 | One-cycle request after an interrupt wake |

## Verification
The stop entry is tried with writes to a neighbouring address and with a 0x87 write that sets every bit except bit 1. Only a correct address and bit decode passes both. While stopped, the bench presents a line already high, a falling edge and a clearing write, none of which may wake the block. Two full warm-ups, started from different lines, check the exact resume cycle and the single wake pulse. A reset in the middle of a warm-up, followed by another full warm-up, shows the counter starts from zero each time, because a count that carried over would resume about 1000 cycles early.

// File: rtl/stop_ctl.sv
module stop_ctl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PCON_ADDR   = 'h87,
  parameter int STOP_BIT    = 1,
  parameter int N_WAKE      = 4,
  parameter int WARM_CYCLES = 65536
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [N_WAKE-1:0] ext_irq,
  output logic              core_clk_en,
  output logic              wake_req
);
  localparam int CNT_W = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARM_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WARM} pstate_t;

  pstate_t           state;
  logic [CNT_W-1:0]  warm_cnt;
  logic [N_WAKE-1:0] irq_s1, irq_s2, irq_prev;
  logic              any_edge, stop_wr, warm_done;

  assign any_edge  = |(irq_s2 & ~irq_prev);
  assign stop_wr   = sfr_we && (sfr_addr == ADDR_W'(PCON_ADDR)) && sfr_wdata[STOP_BIT];
  assign warm_done = (warm_cnt == CNT_LAST);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s1   <= '0;
      irq_s2   <= '0;
      irq_prev <= '0;
    end else begin
      irq_s1   <= ext_irq;
      irq_s2   <= irq_s1;
      irq_prev <= irq_s2;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_RUN;
      warm_cnt <= '0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= 1'b0;
      unique case (state)
        S_RUN:  if (stop_wr) state <= S_STOP;
        S_STOP: if (any_edge) begin
                  state    <= S_WARM;
                  warm_cnt <= '0;
                end
        S_WARM: if (warm_done) begin
                  state    <= S_RUN;
                  warm_cnt <= '0;
                  wake_req <= 1'b1;
                end else begin
                  warm_cnt <= warm_cnt + 1'b1;
                end
        default: state <= S_RUN;
      endcase
    end
  end

  assign core_clk_en = (state == S_RUN);

  p_enter_r1: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (core_clk_en && stop_wr) |=> !core_clk_en);

  p_hold_stop_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (state == S_STOP && !any_edge) |=> (state == S_STOP));

  p_off_while_warm_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (state == S_WARM && !warm_done) |=> !core_clk_en);

  p_full_warm_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> ($past(warm_cnt) == CNT_LAST));

  p_pulse_once_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  p_pulse_on_resume_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wake_req |-> (core_clk_en && !$past(core_clk_en)));

  p_run_ignores_edges_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (core_clk_en && !stop_wr) |=> core_clk_en);
endmodule

// File: tb/stop_ctl_tb.sv
module stop_ctl_tb;
  localparam int W = 65536;

  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic [3:0] ext_irq = '0;
  logic       core_clk_en, wake_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  stop_ctl u_dut (
    .osc_clk(osc_clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .ext_irq(ext_irq), .core_clk_en(core_clk_en),
    .wake_req(wake_req)
  );

  always #10 osc_clk = ~osc_clk;

  always @(posedge osc_clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000) begin
      total++; bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below 180000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge osc_clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(posedge osc_clk);
    @(negedge osc_clk);
    sfr_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  task automatic wait_resume(output int n);
    n = 0;
    do begin
      @(posedge osc_clk); n++;
      @(negedge osc_clk);
    end while (!core_clk_en && n < W + 100);
  endtask

  task automatic t_reset;
    @(negedge osc_clk);
    chk(core_clk_en === 1'b1, "R8 clk_en in reset", core_clk_en, 1);
    chk(wake_req === 1'b0, "R8 wake_req in reset", wake_req, 0);
    rst_n = 1'b1;
    idle(2);
    chk(core_clk_en === 1'b1, "R8 clk_en after reset", core_clk_en, 1);
  endtask

  task automatic t_ignored_writes;
    sfr_write(8'h86, 8'h02);
    chk(core_clk_en === 1'b1, "R1 other address", core_clk_en, 1);
    sfr_write(8'h87, 8'hFD);
    chk(core_clk_en === 1'b1, "R1 bit1 clear", core_clk_en, 1);
    idle(3);
    chk(core_clk_en === 1'b1, "R1 still running", core_clk_en, 1);
  endtask

  task automatic t_run_edges;
    int low = 0, pulses = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge osc_clk); ext_irq[k] = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge osc_clk);
        if (!core_clk_en) low++;
        if (wake_req) pulses++;
      end
      ext_irq[k] = 1'b0;
    end
    chk(low == 0, "R9 clk_en during run edges", low, 0);
    chk(pulses == 0, "R9 wake_req during run edges", pulses, 0);
  endtask

  task automatic t_stop_no_wake;
    int high = 0;
    @(negedge osc_clk); ext_irq[1] = 1'b1;
    idle(4);
    sfr_write(8'h87, 8'h02);
    chk(core_clk_en === 1'b0, "R1 stop entered", core_clk_en, 0);
    for (int i = 0; i < 50; i++) begin @(negedge osc_clk); if (core_clk_en) high++; end
    chk(high == 0, "R3 held level no wake", high, 0);
    ext_irq[1] = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge osc_clk); if (core_clk_en) high++; end
    chk(high == 0, "R3 falling edge no wake", high, 0);
    sfr_write(8'h87, 8'h00);
    idle(3);
    chk(core_clk_en === 1'b0, "R3 write while stopped", core_clk_en, 0);
  endtask

  task automatic t_full_wake(input int line, input string tag);
    int n, late = 0;
    @(negedge osc_clk); ext_irq[line] = 1'b1;
    wait_resume(n);
    chk(n == W + 3, {tag, " warm-up length"}, n, W + 3);
    chk(wake_req === 1'b1, "R7 pulse on resume", wake_req, 1);
    @(negedge osc_clk);
    chk(wake_req === 1'b0, "R7 pulse one cycle", wake_req, 0);
    for (int i = 0; i < 20; i++) begin @(negedge osc_clk); if (!core_clk_en) late++; end
    chk(late == 0, "R6 stays running", late, 0);
    ext_irq = '0;
    idle(4);
  endtask

  task automatic t_reset_in_warm;
    int pulses = 0, low = 0;
    sfr_write(8'h87, 8'h02);
    @(negedge osc_clk); ext_irq[2] = 1'b1;
    for (int i = 0; i < 1000; i++) begin @(negedge osc_clk); if (core_clk_en) low++; end
    chk(low == 0, "R2 off during warm-up", low, 0);
    rst_n = 1'b0;
    @(negedge osc_clk);
    chk(core_clk_en === 1'b1, "R8 reset aborts warm-up", core_clk_en, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge osc_clk); if (wake_req) pulses++; end
    chk(pulses == 0, "R8 no pulse after reset wake", pulses, 0);
    ext_irq = '0;
    idle(4);
  endtask

  task automatic t_reset_in_stop;
    int pulses = 0;
    sfr_write(8'h87, 8'h02);
    idle(5);
    rst_n = 1'b0;
    @(negedge osc_clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge osc_clk); if (wake_req) pulses++; end
    chk(core_clk_en === 1'b1, "R8 reset leaves stop", core_clk_en, 1);
    chk(pulses == 0, "R8 no pulse on reset from stop", pulses, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_ignored_writes();
    t_run_edges();
    t_stop_no_wake();
    t_full_wake(0, "R5 R4 R2 line0");
    t_reset_in_warm();
    t_reset_in_stop();
    sfr_write(8'h87, 8'h02);
    t_full_wake(3, "R8 R5 fresh count line3");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule